// File: doc/BRIEF.md
# Floating-Point Condition-Code Comparator

This block orders two IEEE-754 operands and reports the outcome as a 2-bit condition code. The code is merged into one of four condition fields of a 64-bit floating-point status word. It is purely combinational: the operands, the compare kind, the field index and the current status word go in, and in the same cycle the updated status word and an invalid-operation flag come out. A parameter selects single precision (32-bit operands) or double precision (64-bit operands).

Internally each operand is first classified as zero, finite, infinity or NaN. A decision stage then picks one of six named paths, each producing the code through a `unique case`. The paths, in priority order, are: UNORD (either operand is a NaN), ZEROS (both operands are zero), SIGN (the signs differ), CLASS (same sign, different classes), INF (two infinities of the same sign), and MAG (two finite nonzero operands of the same sign, ordered by magnitude). Signalling compares raise the invalid flag on an unordered result. Quiet compares never raise it.

Top module: `fpcmp_top`

## Requirements
- R1: If either operand has an all-ones exponent and a nonzero fraction (a NaN), the code is unordered (3), whatever the other operand is.
- R2: With the signalling-compare select at 1 and an unordered code, the invalid flag is 1.
- R3: The invalid flag is 0 whenever the code is ordered (0, 1 or 2), and it is always 0 when the select is 0.
- R4: Two zeros (exponent and fraction all zero) compare equal (0), whatever their sign bits.
- R5: If the sign bits differ and the operands are not both zero, the operand with sign bit 1 is the lesser. The code is less (1) when A is negative and greater (2) when B is negative.
- R6: For two positive operands, infinity ranks above finite values and finite values rank above zero. Two infinities of the same sign give equal (0).
- R7: For two negative operands, the magnitude outcome is inverted: the larger magnitude gives less (1) and the smaller gives greater (2).
- R8: Two finite nonzero operands of the same sign are ordered by their exponent and fraction, read together as one unsigned integer. Subnormals count as nonzero finite values, and equal integers give equal (0).
- R9: The code is written to status bits [11:10] for index 0, [33:32] for index 1, [35:34] for index 2 and [37:36] for index 3, with the code's MSB in the upper bit. Every other status bit passes through unchanged.
- R10: With DOUBLE_PREC set, the operands are 64 bits with an 11-bit exponent and a 52-bit fraction. Otherwise they are 32 bits with an 8-bit exponent and a 23-bit fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_cmp | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| fld_idx | input | 2 | Index of the condition field to update |
| op_a | input | OP_W | First operand (32 or 64 bits) |
| op_b | input | OP_W | Second operand (32 or 64 bits) |
| fsr_in | input | 64 | Current status word |
| fsr_out | output | 64 | Status word with the selected field replaced |
| inv_flag | output | 1 | Invalid-operation exception flag |

## Verification
The immediate assertions assume the inputs are settled two-state values. They are evaluated on every change of the combinational logic, so they also assume no caller depends on transient values between input updates. The bench meets this by changing all inputs together on the falling clock edge and sampling one nanosecond later. Its stimulus comes only from a fixed set of well-formed encodings for each precision: signed zeros, extreme subnormals, the smallest normal, values one fraction step apart, the largest finite value, infinities, and quiet, signalling and negative NaNs. Every ordered pair is applied under both compare kinds and all four field indices, over a changing background status word.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UO = 2'd3
    } fcc_t;

    // Class order matters: ZERO < FINITE < INF by magnitude.
    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } fclass_t;

    typedef enum logic [2:0] {
        PATH_UNORD = 3'd0,
        PATH_ZEROS = 3'd1,
        PATH_SIGN  = 3'd2,
        PATH_CLASS = 3'd3,
        PATH_INF   = 3'd4,
        PATH_MAG   = 3'd5
    } cmp_path_t;

    localparam int NUM_FIELDS = 4;

    function automatic int field_lsb(input int idx);
        return (idx == 0) ? 10 : 30 + 2 * idx;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [MAG_W:0]          op,
    output fpcmp_pkg::fclass_t      cls,
    output logic                    sign,
    output logic [MAG_W-1:0]        mag
);
    import fpcmp_pkg::*;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;
    logic             exp_max;
    logic             exp_zero;
    logic             frac_zero;

    assign sign      = op[MAG_W];
    assign mag       = op[MAG_W-1:0];
    assign expo      = op[MAG_W-1:MAN_W];
    assign frac      = op[MAN_W-1:0];
    assign exp_max   = &expo;
    assign exp_zero  = ~|expo;
    assign frac_zero = ~|frac;

    always_comb begin
        unique case ({exp_max, exp_zero})
            2'b10:   cls = frac_zero ? CLS_INF : CLS_NAN;
            2'b01:   cls = frac_zero ? CLS_ZERO : CLS_FINITE;
            default: cls = CLS_FINITE;
        endcase
    end

    always_comb begin
        p_nan_class_r1: assert ((cls == CLS_NAN) == (exp_max && !frac_zero))
            else $error("NaN classification mismatch");
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
    parameter int MAG_W = 31
) (
    input  fpcmp_pkg::fclass_t cls_a,
    input  logic               sign_a,
    input  logic [MAG_W-1:0]   mag_a,
    input  fpcmp_pkg::fclass_t cls_b,
    input  logic               sign_b,
    input  logic [MAG_W-1:0]   mag_b,
    output fpcmp_pkg::fcc_t    cc
);
    import fpcmp_pkg::*;

    cmp_path_t path;

    // smaller: |a| < |b|; neg: both operands negative
    function automatic fcc_t by_magnitude(input logic smaller, input logic neg);
        return (smaller ^ neg) ? CC_LT : CC_GT;
    endfunction

    always_comb begin
        if (cls_a == CLS_NAN || cls_b == CLS_NAN)
            path = PATH_UNORD;
        else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO)
            path = PATH_ZEROS;
        else if (sign_a != sign_b)
            path = PATH_SIGN;
        else if (cls_a != cls_b)
            path = PATH_CLASS;
        else if (cls_a == CLS_INF)
            path = PATH_INF;
        else
            path = PATH_MAG;
    end

    always_comb begin
        unique case (path)
            PATH_UNORD: cc = CC_UO;
            PATH_ZEROS: cc = CC_EQ;
            PATH_SIGN:  cc = sign_a ? CC_LT : CC_GT;
            PATH_CLASS: cc = by_magnitude(cls_a < cls_b, sign_a);
            PATH_INF:   cc = CC_EQ;
            PATH_MAG:   cc = (mag_a == mag_b) ? CC_EQ
                                              : by_magnitude(mag_a < mag_b, sign_a);
            default:    cc = CC_UO;
        endcase
    end

    always_comb begin
        p_nan_unordered_r1: assert (!(cls_a == CLS_NAN || cls_b == CLS_NAN) || cc == CC_UO)
            else $error("NaN operand without unordered code");
        p_zeros_equal_r4: assert (!(cls_a == CLS_ZERO && cls_b == CLS_ZERO) || cc == CC_EQ)
            else $error("two zeros not equal");
        p_sign_split_r5: assert (!(cls_a != CLS_NAN && cls_b != CLS_NAN && sign_a != sign_b
                                   && !(cls_a == CLS_ZERO && cls_b == CLS_ZERO))
                                 || cc == (sign_a ? CC_LT : CC_GT))
            else $error("mixed-sign ordering wrong");
        p_ordered_not_uo_r1: assert (cls_a == CLS_NAN || cls_b == CLS_NAN || cc != CC_UO)
            else $error("unordered code without NaN");
    end

endmodule

// File: rtl/fpcmp_fsr_merge.sv
module fpcmp_fsr_merge #(
    parameter int FSR_W = 64
) (
    input  logic [FSR_W-1:0] fsr_in,
    input  logic [1:0]       fld_idx,
    input  fpcmp_pkg::fcc_t  cc,
    output logic [FSR_W-1:0] fsr_out
);
    import fpcmp_pkg::*;

    logic [1:0]       new_fld [NUM_FIELDS];
    logic [FSR_W-1:0] sel_mask;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int LSB = field_lsb(g);
        assign new_fld[g] = (fld_idx == 2'(g)) ? cc : fsr_in[LSB +: 2];
    end

    always_comb begin
        fsr_out = fsr_in;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            fsr_out[field_lsb(f) +: 2] = new_fld[f];
        end
    end

    always_comb begin
        sel_mask = '0;
        sel_mask[field_lsb(int'(fld_idx)) +: 2] = 2'b11;
        p_others_kept_r9: assert (((fsr_out ^ fsr_in) & ~sel_mask) == '0)
            else $error("unselected status bits changed");
        p_field_written_r9: assert (fsr_out[field_lsb(int'(fld_idx)) +: 2] == cc)
            else $error("selected field not written");
    end

endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top #(
    parameter bit  DOUBLE_PREC = 1'b0,
    parameter int  FSR_W       = 64,
    localparam int EXP_W       = DOUBLE_PREC ? 11 : 8,
    localparam int MAN_W       = DOUBLE_PREC ? 52 : 23,
    localparam int MAG_W       = EXP_W + MAN_W,
    localparam int OP_W        = MAG_W + 1
) (
    input  logic             sig_cmp,
    input  logic [1:0]       fld_idx,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [FSR_W-1:0] fsr_in,
    output logic [FSR_W-1:0] fsr_out,
    output logic             inv_flag
);
    import fpcmp_pkg::*;

    logic [OP_W-1:0]  ops   [2];
    fclass_t          cls   [2];
    logic             sgn   [2];
    logic [MAG_W-1:0] mag   [2];
    fcc_t             cc;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .op   (ops[g]),
            .cls  (cls[g]),
            .sign (sgn[g]),
            .mag  (mag[g])
        );
    end

    fpcmp_order #(
        .MAG_W (MAG_W)
    ) u_order (
        .cls_a  (cls[0]),
        .sign_a (sgn[0]),
        .mag_a  (mag[0]),
        .cls_b  (cls[1]),
        .sign_b (sgn[1]),
        .mag_b  (mag[1]),
        .cc     (cc)
    );

    fpcmp_fsr_merge #(
        .FSR_W (FSR_W)
    ) u_merge (
        .fsr_in  (fsr_in),
        .fld_idx (fld_idx),
        .cc      (cc),
        .fsr_out (fsr_out)
    );

    assign inv_flag = sig_cmp && (cc == CC_UO);

    always_comb begin
        p_inv_on_unord_r2: assert (!(sig_cmp && fsr_out[field_lsb(int'(fld_idx)) +: 2] == 2'd3)
                                   || inv_flag)
            else $error("signalling unordered without invalid flag");
        p_inv_only_unord_r3: assert (!inv_flag
                                     || (sig_cmp && fsr_out[field_lsb(int'(fld_idx)) +: 2] == 2'd3))
            else $error("invalid flag on ordered or quiet compare");
    end

endmodule

// File: tb/test_fpcmp_top.sv
module test_fpcmp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    logic        sig_cmp = 1'b0;
    logic [1:0]  fld_idx = 2'd0;
    logic [31:0] a_s = '0, b_s = '0;
    logic [63:0] a_d = '0, b_d = '0;
    logic [63:0] fsr_in = '0;
    logic [63:0] fsr_s, fsr_d;
    logic        inv_s, inv_d;

    always #2.5 clk = ~clk;

    fpcmp_top #(.DOUBLE_PREC(1'b0)) i_fpcmp_top (
        .sig_cmp (sig_cmp), .fld_idx (fld_idx), .op_a (a_s), .op_b (b_s),
        .fsr_in (fsr_in), .fsr_out (fsr_s), .inv_flag (inv_s)
    );

    fpcmp_top #(.DOUBLE_PREC(1'b1)) i_fpcmp_top_dbl (
        .sig_cmp (sig_cmp), .fld_idx (fld_idx), .op_a (a_d), .op_b (b_d),
        .fsr_in (fsr_in), .fsr_out (fsr_d), .inv_flag (inv_d)
    );

    function automatic logic [63:0] mag_val(int k, bit dbl);
        if (dbl) begin
            case (k)
                0: return 64'h0;
                1: return 64'h1;
                2: return 64'h000F_FFFF_FFFF_FFFF;
                3: return 64'h0010_0000_0000_0000;
                4: return 64'h3FF0_0000_0000_0000;
                5: return 64'h3FF0_0000_0000_0001;
                6: return 64'h3FF8_0000_0000_0000;
                7: return 64'h7FEF_FFFF_FFFF_FFFF;
                default: return 64'h7FF0_0000_0000_0000;
            endcase
        end
        case (k)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'h007F_FFFF;
            3: return 64'h0080_0000;
            4: return 64'h3F80_0000;
            5: return 64'h3F80_0001;
            6: return 64'h3FC0_0000;
            7: return 64'h7F7F_FFFF;
            default: return 64'h7F80_0000;
        endcase
    endfunction

    function automatic logic [63:0] pick(int i, bit dbl);
        logic [63:0] sb;
        sb = dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
        if (i < 9)  return mag_val(i, dbl);
        if (i < 18) return sb | mag_val(i - 9, dbl);
        case (i)
            18: return dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
            19: return dbl ? 64'h7FF0_0000_0000_0001 : 64'h7F80_0001;
            default: return dbl ? 64'hFFF8_0000_0000_0000 : 64'hFFC0_0000;
        endcase
    endfunction

    function automatic bit is_nan(logic [63:0] x, bit dbl);
        if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic logic [63:0] mag_of(logic [63:0] x, bit dbl);
        return dbl ? {1'b0, x[62:0]} : {33'b0, x[30:0]};
    endfunction

    function automatic bit sign_of(logic [63:0] x, bit dbl);
        return dbl ? x[63] : x[31];
    endfunction

    // Signed numeric key: magnitude ordering is monotonic in the encoding.
    function automatic logic [1:0] ref_cc(logic [63:0] a, logic [63:0] b, bit dbl);
        longint ka, kb;
        if (is_nan(a, dbl) || is_nan(b, dbl)) return 2'd3;
        ka = longint'(mag_of(a, dbl));
        kb = longint'(mag_of(b, dbl));
        if (sign_of(a, dbl)) ka = -ka;
        if (sign_of(b, dbl)) kb = -kb;
        if (ka == kb) return 2'd0;
        return (ka < kb) ? 2'd1 : 2'd2;
    endfunction

    function automatic string req_tag(logic [63:0] a, logic [63:0] b, bit dbl);
        bit za, zb;
        if (is_nan(a, dbl) || is_nan(b, dbl)) return "R1";
        za = mag_of(a, dbl) == 0;
        zb = mag_of(b, dbl) == 0;
        if (za && zb) return "R4";
        if (sign_of(a, dbl) != sign_of(b, dbl)) return "R5";
        if (sign_of(a, dbl)) return "R7";
        if (za || zb || mag_of(a, dbl) == mag_val(8, dbl) || mag_of(b, dbl) == mag_val(8, dbl))
            return "R6";
        return "R8";
    endfunction

    task automatic check_one(bit dbl);
        logic [63:0] a, b, exp_fsr, got_fsr;
        logic [1:0]  cc;
        logic        exp_inv, got_inv;
        int          lsb;
        string       pfx;
        a       = dbl ? a_d : {32'b0, a_s};
        b       = dbl ? b_d : {32'b0, b_s};
        cc      = ref_cc(a, b, dbl);
        lsb     = (fld_idx == 2'd0) ? 10 : 30 + 2 * int'(fld_idx);
        exp_fsr = fsr_in;
        exp_fsr[lsb +: 2] = cc;
        exp_inv = sig_cmp && (cc == 2'd3);
        got_fsr = dbl ? fsr_d : fsr_s;
        got_inv = dbl ? inv_d : inv_s;
        pfx     = dbl ? "R10 " : "";
        checks++;
        if (got_fsr !== exp_fsr) begin
            errors++;
            $display("FAIL %s%s R9 a=%h b=%h idx=%0d fsr actual=%h expected=%h",
                     pfx, req_tag(a, b, dbl), a, b, fld_idx, got_fsr, exp_fsr);
        end
        checks++;
        if (got_inv !== exp_inv) begin
            errors++;
            $display("FAIL %s%s a=%h b=%h sig=%0d inv actual=%0d expected=%0d",
                     pfx, exp_inv ? "R2" : "R3", a, b, sig_cmp, got_inv, exp_inv);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands, zero status word.
        @(negedge clk);
        #1;
        checks++;
        if (fsr_s !== 64'h0 || inv_s !== 1'b0) begin
            errors++;
            $display("FAIL R4 R3 idle actual fsr=%h inv=%0d expected fsr=0 inv=0", fsr_s, inv_s);
        end
        begin
            logic [63:0] pat;
            pat = 64'hA5C3_1E96_0F5A_3C71;
            for (int dbl = 0; dbl < 2; dbl++) begin
                for (int i = 0; i < 21; i++) begin
                    for (int j = 0; j < 21; j++) begin
                        for (int s = 0; s < 2; s++) begin
                            for (int k = 0; k < 4; k++) begin
                                @(negedge clk);
                                pat = {pat[62:0], pat[63] ^ pat[62] ^ pat[60] ^ pat[59]};
                                fsr_in  = pat;
                                sig_cmp = s[0];
                                fld_idx = k[1:0];
                                a_s = pick(i, 1'b0);
                                b_s = pick(j, 1'b0);
                                a_d = pick(i, 1'b1);
                                b_d = pick(j, 1'b1);
                                #1;
                                check_one(dbl[0]);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule